// File: doc/BRIEF.md
# Suspend and Wake-Up Sequencer

This block decides when a logic fabric may drop into a low-power hold state and how it comes back out. A suspend request input can be taken directly or through a glitch filter. Before the block commits to suspend, it can optionally wait for an acknowledge from the user logic. Once suspend is committed, the block removes the output enable, raises a write-protect control that freezes clocked state, and then lowers its awake status output.

Wake-up is triggered when the request goes low, or when a masked group of wake pins is active. After awake rises, two programmable delays run. The first re-enables the outputs. The second, which is never shorter than the first, releases write protection and returns the block to normal operation. A one-cycle global set/reset pulse can optionally be issued on wake-up. A configuration-check error input is latched. Once latched, it blocks both entry into suspend and exit from it until the next reset.

Top module: `suspend_wake_seq`

## Requirements
- R1: After reset, awake=1, outEnable=1, writeProtect=0 and gsrPulse=0, and the error latch is clear.
- R2: With the filter and synchronisation off, the first clock edge that samples suspendReq=1 commits suspend. At that edge outEnable goes to 0 and writeProtect goes to 1, and awake goes to 0 one edge later.
- R3: With cfgFilterEn=1, the request takes effect only after it has held a new level for 4 consecutive edges. Suspend then commits on the 5th edge, and a request pulse of 3 edges or fewer is ignored.
- R4: With cfgSyncEn=1, a held request waits with no effect until syncAck=1 is sampled, and suspend commits on that edge. If the request falls while waiting, the block returns to normal operation, and a later acknowledge does nothing.
- R5: While suspended, an effective request of 0 is a wake event. awake rises one edge after the edge that detects the event.
- R6: When cfgMultiWakeEn=1, a pin wakePins[i] at 1 with cfgWakeMask[i]=1 is a wake event (bit i maps to pin i). Masked pins are ignored, and all pins are ignored when cfgMultiWakeEn=0.
- R7: A delay code v stands for v+1 cycles. outEnable rises min(cfgOeDelay,cfgWpDelay)+1 edges after the edge at which awake rises. writeProtect falls cfgWpDelay+1 edges after that same edge, and normal operation resumes then.
- R8: The output re-enable is never later than the write-protect release. An output-enable code larger than the write-protect code is clamped to it, and writeProtect=0 never occurs with outEnable=0.
- R9: Once crcErr is sampled at 1, suspend entry and wake-up are both blocked until reset.
- R10: With cfgGsrEn=1, gsrPulse is high for exactly one cycle, in the cycle awake rises. With cfgGsrEn=0 it stays low.
- R11: While awake=0, outEnable=0 and writeProtect=1, whatever syncAck or the masked pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFilterEn | input | 1 | Pass the request through the glitch filter |
| cfgSyncEn | input | 1 | Wait for syncAck before committing suspend |
| cfgMultiWakeEn | input | 1 | Allow the wake pins to end suspend |
| cfgWakeMask | input | 8 | Per-pin wake enable |
| cfgOeDelay | input | 3 | Output re-enable delay code (v+1 cycles) |
| cfgWpDelay | input | 3 | Write-protect release delay code (v+1 cycles) |
| cfgGsrEn | input | 1 | Issue a set/reset pulse on wake-up |
| suspendReq | input | 1 | Suspend request, active high |
| syncAck | input | 1 | Application acknowledge for suspend entry |
| wakePins | input | 8 | Wake pin inputs |
| crcErr | input | 1 | Configuration-check error, latched internally |
| awake | output | 1 | High when not suspended |
| outEnable | output | 1 | Output enable for the fabric |
| writeProtect | output | 1 | Write protection for clocked state |
| gsrPulse | output | 1 | One-cycle global set/reset on wake-up |

## Verification
The hardest case to reach is the error latch blocking an exit that is already suspended. The error must arrive after suspend has been committed, and only a reset can then recover the block. The stimulus suspends the block, pulses crcErr while awake is low, and drops the request for twenty cycles while checking that awake stays low. It then resets and shows that a new suspend takes effect at once. Combining the filter with synchronisation is another narrow case, because its entry latency of six edges can only be seen by counting edges from the request drive.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE      = 2'd0,
    ST_WAIT_SYNC   = 2'd1,
    ST_SUSPENDED   = 2'd2,
    ST_WAKE_TIMING = 2'd3
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic enterSusp;
    logic startWake;
    logic countEn;
    logic releaseOe;
    logic releaseWp;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic reqEff;
    logic wakeHit;
    logic crcLatched;
    logic awake;
    logic oeDue;
    logic wpDue;
  } seqStatus_t;

endpackage

// File: rtl/swseq_req_filter.sv
module swseq_req_filter #(
  parameter int STABLE_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CNT_W = (STABLE_LEN > 1) ? $clog2(STABLE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_LEN - 1);

  logic [CNT_W-1:0] diffCnt;
  logic             filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffCnt <= '0;
      filtQ   <= 1'b0;
    end else if (rawIn == filtQ) begin
      diffCnt <= '0;
    end else if (diffCnt == LAST) begin
      diffCnt <= '0;
      filtQ   <= rawIn;
    end else begin
      diffCnt <= diffCnt + 1'b1;
    end
  end

  assign filtOut = filtQ;
endmodule

// File: rtl/swseq_datapath.sv
module swseq_datapath
  import swseq_pkg::*;
#(
  parameter int PIN_W    = 8,
  parameter int DLY_W    = 3,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgFilterEn,
  input  logic             cfgMultiWakeEn,
  input  logic [PIN_W-1:0] cfgWakeMask,
  input  logic [DLY_W-1:0] cfgOeDelay,
  input  logic [DLY_W-1:0] cfgWpDelay,
  input  logic             cfgGsrEn,
  input  logic             suspendReq,
  input  logic [PIN_W-1:0] wakePins,
  input  logic             crcErr,
  input  seqStrobe_t       strobe,
  output seqStatus_t       status,
  output logic             awake,
  output logic             outEnable,
  output logic             writeProtect,
  output logic             gsrPulse
);
  localparam int CNT_W = DLY_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic reqFilt;
  logic reqEff;

  swseq_req_filter #(.STABLE_LEN(FILT_LEN)) u_filter (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (suspendReq),
    .filtOut (reqFilt)
  );

  assign reqEff = cfgFilterEn ? reqFilt : suspendReq;

  // masked wake pins
  logic [PIN_W-1:0] pinHit;
  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign pinHit[i] = wakePins[i] & cfgWakeMask[i];
  end

  // output re-enable delay never exceeds write-protect delay
  logic [DLY_W-1:0] oeEff;
  assign oeEff = (cfgOeDelay > cfgWpDelay) ? cfgWpDelay : cfgOeDelay;

  logic [CNT_W-1:0] tmrCnt;
  logic suspFlag, awakeQ, oeQ, wpQ, crcQ, wakeDly, gsrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt   <= '0;
      suspFlag <= 1'b0;
      awakeQ   <= 1'b1;
      oeQ      <= 1'b1;
      wpQ      <= 1'b0;
      crcQ     <= 1'b0;
      wakeDly  <= 1'b0;
      gsrQ     <= 1'b0;
    end else begin
      crcQ    <= crcQ | crcErr;
      awakeQ  <= ~suspFlag;
      wakeDly <= strobe.startWake;
      gsrQ    <= wakeDly & cfgGsrEn;

      if (strobe.enterSusp)      suspFlag <= 1'b1;
      else if (strobe.startWake) suspFlag <= 1'b0;

      if (strobe.startWake)                        tmrCnt <= '0;
      else if (strobe.countEn && tmrCnt != CNT_MAX) tmrCnt <= tmrCnt + 1'b1;

      if (strobe.enterSusp)      oeQ <= 1'b0;
      else if (strobe.releaseOe) oeQ <= 1'b1;

      if (strobe.enterSusp)      wpQ <= 1'b1;
      else if (strobe.releaseWp) wpQ <= 1'b0;
    end
  end

  always_comb begin
    status.reqEff     = reqEff;
    status.wakeHit    = ~reqEff | (cfgMultiWakeEn & (|pinHit));
    status.crcLatched = crcQ;
    status.awake      = awakeQ;
    status.oeDue      = (tmrCnt == {1'b0, oeEff});
    status.wpDue      = (tmrCnt == {1'b0, cfgWpDelay});
  end

  assign awake        = awakeQ;
  assign outEnable    = oeQ;
  assign writeProtect = wpQ;
  assign gsrPulse     = gsrQ;
endmodule

// File: rtl/swseq_ctrl.sv
module swseq_ctrl
  import swseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgSyncEn,
  input  logic       syncAck,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (status.reqEff && !status.crcLatched) begin
          if (cfgSyncEn) begin
            stateNext = ST_WAIT_SYNC;
          end else begin
            strobe.enterSusp = 1'b1;
            stateNext        = ST_SUSPENDED;
          end
        end
      end
      ST_WAIT_SYNC: begin
        if (status.crcLatched || !status.reqEff) begin
          stateNext = ST_ACTIVE;
        end else if (syncAck) begin
          strobe.enterSusp = 1'b1;
          stateNext        = ST_SUSPENDED;
        end
      end
      ST_SUSPENDED: begin
        if (status.wakeHit && !status.crcLatched) begin
          strobe.startWake = 1'b1;
          stateNext        = ST_WAKE_TIMING;
        end
      end
      ST_WAKE_TIMING: begin
        if (status.awake) begin
          strobe.countEn   = 1'b1;
          strobe.releaseOe = status.oeDue;
          if (status.wpDue) begin
            strobe.releaseWp = 1'b1;
            stateNext        = ST_ACTIVE;
          end
        end
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end
endmodule

// File: rtl/suspend_wake_seq.sv
module suspend_wake_seq
  import swseq_pkg::*;
#(
  parameter int PIN_W    = 8,
  parameter int DLY_W    = 3,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgFilterEn,
  input  logic             cfgSyncEn,
  input  logic             cfgMultiWakeEn,
  input  logic [PIN_W-1:0] cfgWakeMask,
  input  logic [DLY_W-1:0] cfgOeDelay,
  input  logic [DLY_W-1:0] cfgWpDelay,
  input  logic             cfgGsrEn,
  input  logic             suspendReq,
  input  logic             syncAck,
  input  logic [PIN_W-1:0] wakePins,
  input  logic             crcErr,
  output logic             awake,
  output logic             outEnable,
  output logic             writeProtect,
  output logic             gsrPulse
);
  seqStrobe_t strobe;
  seqStatus_t status;

  swseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgSyncEn (cfgSyncEn),
    .syncAck   (syncAck),
    .status    (status),
    .strobe    (strobe)
  );

  swseq_datapath #(
    .PIN_W    (PIN_W),
    .DLY_W    (DLY_W),
    .FILT_LEN (FILT_LEN)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .cfgFilterEn    (cfgFilterEn),
    .cfgMultiWakeEn (cfgMultiWakeEn),
    .cfgWakeMask    (cfgWakeMask),
    .cfgOeDelay     (cfgOeDelay),
    .cfgWpDelay     (cfgWpDelay),
    .cfgGsrEn       (cfgGsrEn),
    .suspendReq     (suspendReq),
    .wakePins       (wakePins),
    .crcErr         (crcErr),
    .strobe         (strobe),
    .status         (status),
    .awake          (awake),
    .outEnable      (outEnable),
    .writeProtect   (writeProtect),
    .gsrPulse       (gsrPulse)
  );
endmodule

// File: rtl/suspend_wake_seq_chk.sv
module suspend_wake_seq_chk (
  input logic clk,
  input logic rstN,
  input logic crcErr,
  input logic awake,
  input logic outEnable,
  input logic writeProtect,
  input logic gsrPulse
);
  logic crcSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcSeen <= 1'b0;
    else       crcSeen <= crcSeen | crcErr;
  end

  assert_wp_covers_oe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !writeProtect |-> outEnable);

  assert_asleep_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    !awake |-> (writeProtect && !outEnable));

  assert_gsr_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    gsrPulse |=> !gsrPulse);

  assert_gsr_on_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    gsrPulse |-> $rose(awake));

  assert_oe_after_awake_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> (awake && $past(awake)));

  assert_crc_no_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (crcSeen && $past(crcSeen) && awake) |=> awake);

  assert_crc_no_wake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (crcSeen && $past(crcSeen) && !awake) |=> !awake);
endmodule

bind suspend_wake_seq suspend_wake_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .crcErr       (crcErr),
  .awake        (awake),
  .outEnable    (outEnable),
  .writeProtect (writeProtect),
  .gsrPulse     (gsrPulse)
);

// File: tb/suspend_wake_seq_tb.sv
module suspend_wake_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgFilterEn = 0, cfgSyncEn = 0, cfgMultiWakeEn = 0, cfgGsrEn = 0;
  logic [7:0] cfgWakeMask = '0;
  logic [2:0] cfgOeDelay = 3'd0, cfgWpDelay = 3'd4;
  logic suspendReq = 0, syncAck = 0, crcErr = 0;
  logic [7:0] wakePins = '0;
  logic awake, outEnable, writeProtect, gsrPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  suspend_wake_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgFilterEn(cfgFilterEn), .cfgSyncEn(cfgSyncEn),
    .cfgMultiWakeEn(cfgMultiWakeEn), .cfgWakeMask(cfgWakeMask),
    .cfgOeDelay(cfgOeDelay), .cfgWpDelay(cfgWpDelay), .cfgGsrEn(cfgGsrEn),
    .suspendReq(suspendReq), .syncAck(syncAck), .wakePins(wakePins),
    .crcErr(crcErr), .awake(awake), .outEnable(outEnable),
    .writeProtect(writeProtect), .gsrPulse(gsrPulse)
  );

  typedef struct packed {
    logic       filt;
    logic       sync;
    logic       multi;
    logic       pinWake;
    logic [7:0] mask;
    logic [2:0] pinBit;
    logic [2:0] oeCode;
    logic [2:0] wpCode;
    logic       gsr;
    logic [3:0] expEntry;
    logic [3:0] expAwake;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 3'd1, 3'd4, 1'b0, 4'd1, 4'd2},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 3'd0, 3'd0, 1'b1, 4'd5, 4'd6},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 3'd2, 3'd7, 1'b0, 4'd2, 4'd2},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h0F, 3'd2, 3'd3, 3'd3, 1'b1, 4'd1, 4'd2},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 3'd7, 3'd6, 3'd2, 1'b0, 4'd1, 4'd2},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 3'd7, 3'd7, 1'b1, 4'd6, 4'd6}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    suspendReq = 0; syncAck = 0; crcErr = 0; wakePins = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkIdle(input string req);
    check(req, "awake", int'(awake), 1);
    check(req, "outEnable", int'(outEnable), 1);
    check(req, "writeProtect", int'(writeProtect), 0);
    check(req, "gsrPulse", int'(gsrPulse), 0);
  endtask

  task automatic runVector(input int idx);
    vec_t v;
    int entryE, awE, oeE, wpE, gE, gCnt, mn;
    v = VECS[idx];
    entryE = 0; awE = 0; oeE = 0; wpE = 0; gE = 0; gCnt = 0;
    @(negedge clk);
    cfgFilterEn = v.filt; cfgSyncEn = v.sync; cfgMultiWakeEn = v.multi;
    cfgWakeMask = v.mask; cfgOeDelay = v.oeCode; cfgWpDelay = v.wpCode;
    cfgGsrEn = v.gsr;
    suspendReq = 1'b1; syncAck = v.sync;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (entryE == 0 && !outEnable) entryE = k;
    end
    check(v.filt ? "R3" : (v.sync ? "R4" : "R2"), "entry edge", entryE, int'(v.expEntry));
    // wake
    if (v.pinWake) wakePins = 8'(1) << v.pinBit;
    else           suspendReq = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (awE == 0 && awake) begin
        awE = k;
        if (v.pinWake) begin suspendReq = 1'b0; wakePins = '0; end
      end
      if (oeE == 0 && outEnable) oeE = k;
      if (wpE == 0 && !writeProtect) wpE = k;
      if (gsrPulse) begin gCnt++; if (gE == 0) gE = k; end
    end
    syncAck = 1'b0;
    mn = (v.oeCode > v.wpCode) ? int'(v.wpCode) : int'(v.oeCode);
    check(v.pinWake ? "R6" : "R5", "awake rise edge", awE, int'(v.expAwake));
    check(v.oeCode > v.wpCode ? "R8" : "R7", "outEnable rise edge", oeE, int'(v.expAwake) + mn + 1);
    check("R7", "writeProtect fall edge", wpE, int'(v.expAwake) + int'(v.wpCode) + 1);
    check("R10", "gsr first edge", gE, v.gsr ? int'(v.expAwake) : 0);
    check("R10", "gsr count", gCnt, v.gsr ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int stay;
    doReset();
    checkIdle("R1");

    for (int i = 0; i < NVEC; i++) runVector(i);

    // R3: short pulse through the filter is ignored
    @(negedge clk);
    cfgFilterEn = 1; cfgSyncEn = 0; cfgMultiWakeEn = 0;
    suspendReq = 1;
    repeat (3) @(negedge clk);
    suspendReq = 0;
    stay = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (!outEnable) stay = 0; end
    check("R3", "glitch ignored", stay, 1);

    // R4: waits for acknowledge, commits on ack edge
    cfgFilterEn = 0; cfgSyncEn = 1; syncAck = 0; suspendReq = 1;
    stay = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (!outEnable) stay = 0; end
    check("R4", "held without ack", stay, 1);
    syncAck = 1;
    @(negedge clk);
    check("R4", "commit on ack edge outEnable", int'(outEnable), 0);
    suspendReq = 0; syncAck = 0;
    repeat (20) @(negedge clk);
    check("R4", "back to normal writeProtect", int'(writeProtect), 0);
    // R4: request withdrawn while waiting, later ack has no effect
    suspendReq = 1;
    repeat (2) @(negedge clk);
    suspendReq = 0;
    @(negedge clk);
    syncAck = 1;
    stay = 1;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (!outEnable || !awake) stay = 0; end
    check("R4", "withdrawn request, ack ignored", stay, 1);
    syncAck = 0;

    // R6/R11: masked and disabled pins ignored while suspended
    @(negedge clk);
    cfgSyncEn = 0; cfgMultiWakeEn = 1; cfgWakeMask = 8'h0F; suspendReq = 1;
    repeat (3) @(negedge clk);
    wakePins = 8'hF0;
    stay = 1;
    for (int k = 0; k < 10; k++) begin
      syncAck = ~syncAck;
      @(negedge clk);
      if (awake || outEnable || !writeProtect) stay = 0;
    end
    check("R6", "masked pins ignored", stay, 1);
    check("R11", "held outputs while asleep", int'(writeProtect) * 2 + int'(outEnable), 2);
    syncAck = 0; cfgMultiWakeEn = 0; cfgWakeMask = 8'hFF; wakePins = 8'hFF;
    stay = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (awake) stay = 0; end
    check("R6", "pins ignored when disabled", stay, 1);
    wakePins = '0; suspendReq = 0;
    repeat (20) @(negedge clk);
    check("R5", "recovered by request low", int'(awake), 1);

    // R9: error blocks entry
    crcErr = 1;
    @(negedge clk);
    crcErr = 0; suspendReq = 1;
    stay = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (!outEnable || !awake) stay = 0; end
    check("R9", "entry blocked", stay, 1);
    doReset();
    checkIdle("R1");
    // R9: error blocks wake
    suspendReq = 1;
    repeat (3) @(negedge clk);
    check("R2", "asleep before error", int'(awake), 0);
    crcErr = 1;
    @(negedge clk);
    crcErr = 0; suspendReq = 0;
    stay = 1;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (awake) stay = 0; end
    check("R9", "wake blocked", stay, 1);
    doReset();
    check("R1", "awake after reset", int'(awake), 1);
    suspendReq = 1;
    @(negedge clk);
    check("R9", "latch cleared by reset, entry works", int'(outEnable), 0);
    suspendReq = 0;
    repeat (20) @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule